// File: doc/BRIEF.md
# Self-Synchronizing Bit-Serial Scrambler and Descrambler

This block whitens a serial bit stream on the transmit side and restores it on the receive side of a spread-spectrum baseband path. Both directions use a 7-bit history register and the feedback polynomial x^7 + x^4 + 1. One bit per direction is processed on each cycle in which the bit-enable strobe is high. Data arrives least significant bit of each byte first. The scrambled and descrambled bits are registered and leave the block one cycle later, together with a shared valid flag.

The transmit history is loaded from a 7-bit seed input when a start-of-frame strobe is seen. The receive history is simply the last seven received bits, so the receive side needs no alignment with the transmitter and falls into step after seven bits. A bypass input forces both feedback terms to zero, so each output copies its input while the history registers keep shifting. The scrambler keeps the known weakness of this polynomial: some periodic inputs leave it in a state where it stops whitening the data.

Top module: `scrambler_pair`

## Requirements
- R1: A high `rst` at a rising edge clears both history registers, both data outputs and `outValid` to zero. With `bitEn` and `sof` low after reset, a zero transmit input gives a zero transmit output.
- R2: Transmit output = input XOR h7 XOR h4, where hk is the transmit output from k enabled steps earlier. The transmit output bit is then shifted into the history.
- R3: On a cycle with `sof` high, the transmit history is replaced by `txSeed`. `txSeed[k]` acts as the output from k+1 steps earlier, so bit 6 is h7 and bit 3 is h4.
- R4: When `sof` and `bitEn` are high in the same cycle, the bit is scrambled with the seed as its history.
- R5: Receive output = received bit XOR r7 XOR r4, where rk is the received bit from k enabled steps earlier. The received bit, not the output, enters the history. After 7 enabled bits of a scrambled stream, the receive output equals the original data whatever the starting history.
- R6: While `bypass` is high, `txOut` equals `txIn` and `rxOut` equals `rxIn` of the enabled cycle. Both histories still shift.
- R7: In a cycle with `bitEn` low, the data outputs and the histories hold their values. The only exception is a seed load under R3.
- R8: `outValid` is high exactly in the cycle after a cycle with `bitEn` high. The data outputs change only in that cycle.
- R9: An all-zero transmit history fed zeros produces zeros indefinitely. An all-ones history fed ones produces ones indefinitely.
- R10: `sof` and `txSeed` have no effect on the receive history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitEn | input | 1 | Process one bit in each direction this cycle |
| sof | input | 1 | Start of frame: load the transmit seed |
| bypass | input | 1 | Force the feedback taps to zero |
| txSeed | input | 7 | Transmit seed |
| txIn | input | 1 | Transmit data bit |
| rxIn | input | 1 | Received scrambled bit |
| txOut | output | 1 | Scrambled bit, registered |
| rxOut | output | 1 | Descrambled bit, registered |
| outValid | output | 1 | Outputs updated in this cycle |

## Verification
Every result is due one rising edge after the cycle that presents its bit. This holds for the two data outputs and for `outValid`, and a seed strobe changes the history at that same edge. The bench drives inputs at the falling edge and samples one time unit after the next rising edge. It compares each output against a reference model that is advanced only when the stimulus is applied. The self-synchronization check begins with the eighth bit of each frame, after garbage has been fed to the receive side between frames.

// File: rtl/scr_pkg.sv
package scr_pkg;
  // Strobes passed from the control module to each datapath lane.
  typedef struct packed {
    logic advance;   // shift one bit this cycle
    logic loadSeed;  // replace the transmit history with the seed
    logic tapsOn;    // feedback taps enabled (low in bypass)
  } scrStrobe_t;
endpackage

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bitEn,
  input  logic       sof,
  input  logic       bypass,
  output scrStrobe_t strobe,
  output logic       outValid
);

  always_comb begin
    strobe.advance  = bitEn & ~rst;
    strobe.loadSeed = sof & ~rst;
    strobe.tapsOn   = ~bypass;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= bitEn;
  end

  // R8: the valid flag follows the bit strobe by one cycle
  a_r8_valid_rise: assert property (@(posedge clk) disable iff (rst)
    bitEn |=> outValid);
  a_r8_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !bitEn |=> !outValid);

endmodule

// File: rtl/scr_datapath.sv
module scr_datapath
  import scr_pkg::*;
#(
  parameter int REG_W      = 7,
  parameter int TAP_HI     = 7,
  parameter int TAP_LO     = 4,
  parameter bit DESCRAMBLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  scrStrobe_t       strobe,
  input  logic [REG_W-1:0] seedIn,
  input  logic             inBit,
  output logic             outBit
);

  localparam int HI_IDX = TAP_HI - 1;
  localparam int LO_IDX = TAP_LO - 1;

  logic [REG_W-1:0] histReg;
  logic [REG_W-1:0] baseHist;
  logic             feedBit;
  logic             resultBit;
  logic             shiftBit;

  generate
    if (DESCRAMBLE) begin : g_rx
      // Self-synchronizing: history is the received stream itself.
      logic unusedRxInputs;
      assign unusedRxInputs = ^{seedIn, strobe.loadSeed};
      assign baseHist = histReg;
      assign shiftBit = inBit;

      // R5: the received bit, not the output, enters the history
      a_r5_rx_shift: assert property (@(posedge clk) disable iff (rst)
        strobe.advance |=> histReg[0] == $past(inBit));
      // R10: the start-of-frame strobe leaves the receive history alone
      a_r10_rx_no_seed: assert property (@(posedge clk) disable iff (rst)
        !strobe.advance |=> $stable(histReg));
    end else begin : g_tx
      assign baseHist = strobe.loadSeed ? seedIn : histReg;
      assign shiftBit = resultBit;

      // R3: a seed strobe without a bit replaces the history
      a_r3_seed_load: assert property (@(posedge clk) disable iff (rst)
        strobe.loadSeed && !strobe.advance |=> histReg == $past(seedIn));
      // R9: zero history with zero data stays locked at zero
      a_r9_zero_lock: assert property (@(posedge clk) disable iff (rst)
        strobe.advance && !strobe.loadSeed && histReg == '0 && !inBit
        |=> histReg == '0 && !outBit);
      // R2: the scrambled output is what enters the history
      a_r2_tx_shift: assert property (@(posedge clk) disable iff (rst)
        strobe.advance |=> histReg[0] == outBit);
    end
  endgenerate

  assign feedBit   = strobe.tapsOn & (baseHist[HI_IDX] ^ baseHist[LO_IDX]);
  assign resultBit = inBit ^ feedBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      histReg <= '0;
      outBit  <= 1'b0;
    end else if (strobe.advance) begin
      histReg <= {baseHist[REG_W-2:0], shiftBit};
      outBit  <= resultBit;
    end else begin
      histReg <= baseHist;
    end
  end

  // R6: with the taps forced off the output copies the input
  a_r6_bypass_copy: assert property (@(posedge clk) disable iff (rst)
    strobe.advance && !strobe.tapsOn |=> outBit == $past(inBit));
  // R7: no bit strobe means the output holds
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.advance |=> $stable(outBit));

endmodule

// File: rtl/scrambler_pair.sv
module scrambler_pair
  import scr_pkg::*;
#(
  parameter int REG_W  = 7,
  parameter int TAP_HI = 7,
  parameter int TAP_LO = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bitEn,
  input  logic             sof,
  input  logic             bypass,
  input  logic [REG_W-1:0] txSeed,
  input  logic             txIn,
  input  logic             rxIn,
  output logic             txOut,
  output logic             rxOut,
  output logic             outValid
);

  scrStrobe_t strobe;

  scr_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bitEn    (bitEn),
    .sof      (sof),
    .bypass   (bypass),
    .strobe   (strobe),
    .outValid (outValid)
  );

  scr_datapath #(
    .REG_W(REG_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .DESCRAMBLE(1'b0)
  ) u_tx (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .seedIn (txSeed),
    .inBit  (txIn),
    .outBit (txOut)
  );

  scr_datapath #(
    .REG_W(REG_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .DESCRAMBLE(1'b1)
  ) u_rx (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .seedIn (txSeed),
    .inBit  (rxIn),
    .outBit (rxOut)
  );

  // R8: outputs change only in a valid cycle
  a_r8_quiet_out: assert property (@(posedge clk) disable iff (rst)
    !bitEn |=> $stable(txOut) && $stable(rxOut));

endmodule

// File: tb/tb_scrambler_pair.sv
module tb_scrambler_pair;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, bitEn, sof, bypass, txIn, rxIn;
  logic [6:0] txSeed;
  logic txOut, rxOut, outValid;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // reference model state
  logic [6:0] mTx, mRx;
  logic lastTx, lastRx;

  always #(CLK_PERIOD/2) clk = ~clk;

  scrambler_pair dut (
    .clk(clk), .rst(rst), .bitEn(bitEn), .sof(sof), .bypass(bypass),
    .txSeed(txSeed), .txIn(txIn), .rxIn(rxIn),
    .txOut(txOut), .rxOut(rxOut), .outValid(outValid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic peekTx(input logic d, input logic doSof,
                                  input logic [6:0] sd, input logic byp);
    logic [6:0] b;
    b = doSof ? sd : mTx;
    return d ^ (~byp & (b[6] ^ b[3]));
  endfunction

  // Apply one cycle at the falling edge, check after the next rising edge.
  task automatic runBit(input logic en, input logic doSof, input logic [6:0] sd,
                        input logic txb, input logic rxb, input logic byp,
                        input string tag);
    logic [6:0] base;
    logic eT, eR;
    base = doSof ? sd : mTx;
    eT = txb ^ (~byp & (base[6] ^ base[3]));
    eR = rxb ^ (~byp & (mRx[6] ^ mRx[3]));
    if (en) begin
      mTx = {base[5:0], eT};
      mRx = {mRx[5:0], rxb};
      lastTx = eT;
      lastRx = eR;
    end else begin
      mTx = base;
    end
    bitEn = en; sof = doSof; txSeed = sd; txIn = txb; rxIn = rxb; bypass = byp;
    @(posedge clk);
    #1;
    check(txOut === lastTx, {tag, " txOut"}, int'(txOut), int'(lastTx));
    check(rxOut === lastRx, {tag, " rxOut"}, int'(rxOut), int'(lastRx));
    check(outValid === en, "R8 outValid", int'(outValid), int'(en));
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1; bitEn = 1'b1; sof = 1'b0; bypass = 1'b0;
    txSeed = 7'h55; txIn = 1'b1; rxIn = 1'b1;
    @(posedge clk);
    #1;
    check(txOut === 1'b0, "R1 txOut reset", int'(txOut), 0);
    check(rxOut === 1'b0, "R1 rxOut reset", int'(rxOut), 0);
    check(outValid === 1'b0, "R1 outValid reset", int'(outValid), 0);
    @(negedge clk);
    rst = 1'b0; bitEn = 1'b0;
    mTx = '0; mRx = '0; lastTx = 1'b0; lastRx = 1'b0;
  endtask

  initial begin
    rst = 1'b1; bitEn = 1'b0; sof = 1'b0; bypass = 1'b0;
    txSeed = '0; txIn = 1'b0; rxIn = 1'b0;
    @(negedge clk);
    doReset();

    // R1: cleared history, zero data stays zero without a seed
    for (int i = 0; i < 8; i++) runBit(1'b1, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0, "R1");

    // Sweep every seed: R2, R3, R4, R5, R10
    for (int s = 0; s < 128; s++) begin
      // garbage on the receive side between frames
      for (int j = 0; j < 5; j++) begin
        logic g;
        g = 1'(((s * 45 + j * 17) >> 2) & 1);
        runBit(1'b1, 1'b0, 7'(s ^ 7'h2A), 1'(j & 1), g, 1'b0, "R10");
      end
      if ((s & 1) == 0)
        runBit(1'b0, 1'b1, 7'(s), 1'b0, 1'b0, 1'b0, "R3");
      for (int i = 0; i < 24; i++) begin
        int b;
        logic d, doSof, rxb;
        b = ((s * 29) + (i / 8) * 71) & 255;
        d = 1'((b >> (i % 8)) & 1);
        doSof = ((s & 1) == 1) && (i == 0);
        rxb = peekTx(d, doSof, 7'(s), 1'b0);
        runBit(1'b1, doSof, 7'(s), d, rxb, 1'b0, doSof ? "R4" : "R2");
        if (i >= 7)
          check(rxOut === d, "R5 self-sync", int'(rxOut), int'(d));
      end
    end

    // R7: no bit strobe, toggling data, outputs and histories hold
    for (int i = 0; i < 6; i++) runBit(1'b0, 1'b0, 7'h11, 1'(i & 1), 1'(~i & 1), 1'b0, "R7");
    for (int i = 0; i < 10; i++) runBit(1'b1, 1'b0, 7'h00, 1'(i % 3 == 0), 1'(i & 1), 1'b0, "R7 resume");

    // R6: bypass copies inputs, histories keep shifting
    for (int i = 0; i < 20; i++) begin
      logic tb, rb;
      tb = 1'((i * 5 + 1) % 3 == 0);
      rb = 1'(i % 2);
      runBit(1'b1, 1'b0, 7'h00, tb, rb, 1'b1, "R6");
      check(txOut === tb, "R6 tx copy", int'(txOut), int'(tb));
      check(rxOut === rb, "R6 rx copy", int'(rxOut), int'(rb));
    end
    for (int i = 0; i < 10; i++) runBit(1'b1, 1'b0, 7'h00, 1'(i & 1), 1'b1, 1'b0, "R6 after");

    // R9: lock-up on all zeros and all ones
    runBit(1'b0, 1'b1, 7'h00, 1'b0, 1'b0, 1'b0, "R9 seed");
    for (int i = 0; i < 16; i++) begin
      runBit(1'b1, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0, "R9 zeros");
      check(txOut === 1'b0, "R9 zero lock", int'(txOut), 0);
    end
    runBit(1'b0, 1'b1, 7'h7F, 1'b0, 1'b0, 1'b0, "R9 seed");
    for (int i = 0; i < 16; i++) begin
      runBit(1'b1, 1'b0, 7'h00, 1'b1, 1'b1, 1'b0, "R9 ones");
      check(txOut === 1'b1, "R9 ones lock", int'(txOut), 1);
    end

    // R1: mid-run reset, then zero data needs no seed
    doReset();
    for (int i = 0; i < 10; i++) begin
      runBit(1'b1, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0, "R1 post");
      check(txOut === 1'b0, "R1 cleared", int'(txOut), 0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule